// File: doc/BRIEF.md
# Chunked Block-Write Packetizer

This block sits between a payload source and a byte-wide SPI shifter. It runs after a bulk-write command has already been accepted by the peripheral. A requester gives a total byte count, a CRC-enable flag and a one-cycle start. The block then streams the payload to the shifter in chunks of at most `CHUNK_MAX` bytes. Each chunk begins with a framing byte that says where the chunk sits in the transfer. When CRC is enabled, each chunk ends with two placeholder check bytes.

Payload bytes arrive on a valid/ready stream and leave on another valid/ready stream. Both streams carry the same back-pressure, so a stalled shifter stalls the sequence without losing its place. The block waits for no reply between chunks. It refuses any transfer too short to be a block write. A one-cycle pulse reports that the last byte of the transfer has been taken.

Top module: `blk_wr_packetizer`

## Requirements
- R1: Each chunk is preceded by a framing byte of value 0xF0 OR'd with a 2-bit position code in bits [1:0]. The code is 3 whenever the bytes still to send are `CHUNK_MAX` (default 8192) or fewer.
- R2: In a transfer longer than `CHUNK_MAX`, the first chunk carries code 1 and each later full-size chunk carries code 2.
- R3: Each chunk carries exactly min(remaining, `CHUNK_MAX`) payload bytes, passed through unchanged and in order.
- R4: With the CRC-enable flag (latched at start) set, each chunk's payload is followed by exactly two bytes of value 0x00. With the flag clear, no such bytes are sent.
- R5: No wait is inserted between chunks. With the source always valid and the sink always ready, every busy cycle transfers one output byte.
- R6: A start with a total count of 4 or less is refused. `reject` pulses in the cycle after start, no output byte is sent, `in_ready` stays low and `busy` stays low. A count of 5 is accepted.
- R7: While `out_ready` is low, a framing or check byte holds `out_valid` high and keeps `out_data` stable. The byte stream sent under back-pressure is identical to the stream sent without it.
- R8: `done` is a single-cycle pulse in the cycle after the final byte (payload or check) is accepted. `busy` is low in that cycle. Exactly one pulse occurs per transfer.
- R9: After reset, `busy`, `done`, `reject`, `out_valid` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a transfer (sampled while idle) |
| total_len | input | LEN_W | Payload byte count for the transfer |
| crc_en | input | 1 | Append two check bytes after each chunk |
| busy | output | 1 | Transfer in progress |
| reject | output | 1 | Pulse: last start was refused (count too small) |
| done | output | 1 | Pulse: final byte of the transfer accepted |
| in_data | input | 8 | Payload byte from source |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Packetizer takes the payload byte |
| out_data | output | 8 | Byte to the SPI shifter |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Shifter takes the output byte |

## Verification
The hardest case to reach is a transfer spanning three chunks. Only such a transfer shows the first, middle and last position codes in a row. A single run of 2×`CHUNK_MAX`+10 bytes reaches it at the default chunk size. That run uses CRC enabled and a periodic stall on both streams, so the chunk boundaries fall during stalled cycles. A second long run at full rate with CRC off checks that the chunk boundaries add no idle cycle. Runs at exactly `CHUNK_MAX` and `CHUNK_MAX`+1 bytes pin down where the code changes from 3 to a 1/3 pair.

// File: rtl/blk_wr_packetizer.sv
module blk_wr_packetizer #(
  parameter int CHUNK_MAX = 8192,
  parameter int LEN_W     = 24,
  parameter int MIN_LEN   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] total_len,
  input  logic             crc_en,
  output logic             busy,
  output logic             reject,
  output logic             done,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready
);
  localparam int CNT_W = $clog2(CHUNK_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_MARK, S_DATA, S_TAIL} st_t;

  st_t              st;
  logic [LEN_W-1:0] rem_q;
  logic [CNT_W-1:0] left_q;
  logic             first_q, crc_q, tail_q, done_q, reject_q;

  wire fits          = rem_q <= LEN_W'(CHUNK_MAX);
  wire [1:0] code    = fits ? 2'd3 : (first_q ? 2'd1 : 2'd2);
  wire [CNT_W-1:0] chunk_len = fits ? CNT_W'(rem_q) : CNT_W'(CHUNK_MAX);

  assign busy      = st != S_IDLE;
  assign done      = done_q;
  assign reject    = reject_q;
  assign in_ready  = (st == S_DATA) && out_ready;
  assign out_valid = (st == S_MARK) || (st == S_TAIL) || ((st == S_DATA) && in_valid);
  assign out_data  = (st == S_MARK) ? {6'h3C, code} :
                     (st == S_DATA) ? in_data : 8'h00;

  wire fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rem_q <= '0;
      left_q <= '0;
      first_q <= 1'b0;
      crc_q <= 1'b0;
      tail_q <= 1'b0;
      done_q <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      reject_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (total_len < LEN_W'(MIN_LEN)) begin
            reject_q <= 1'b1;
          end else begin
            rem_q <= total_len;
            first_q <= 1'b1;
            crc_q <= crc_en;
            st <= S_MARK;
          end
        end
        S_MARK: if (fire) begin
          left_q <= chunk_len;
          first_q <= 1'b0;
          st <= S_DATA;
        end
        S_DATA: if (fire) begin
          rem_q <= rem_q - 1'b1;
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) begin
            if (crc_q) begin
              tail_q <= 1'b0;
              st <= S_TAIL;
            end else if (rem_q == LEN_W'(1)) begin
              done_q <= 1'b1;
              st <= S_IDLE;
            end else begin
              st <= S_MARK;
            end
          end
        end
        default: if (fire) begin
          tail_q <= 1'b1;
          if (tail_q) begin
            if (rem_q == '0) begin
              done_q <= 1'b1;
              st <= S_IDLE;
            end else begin
              st <= S_MARK;
            end
          end
        end
      endcase
    end
  end

  p_marker_form_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MARK) |-> (out_data[7:2] == 6'h3C) && (out_data[1:0] != 2'd0));

  p_chunk_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |-> (left_q != '0) && (left_q <= CNT_W'(CHUNK_MAX)));

  p_tail_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TAIL) |-> (out_data == 8'h00) && crc_q);

  p_no_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fire && !done_q) |=> (busy && (st != S_DATA)) ? out_valid : 1'b1);

  p_reject_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !busy && !out_valid && !in_ready);

  p_hold_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && (st != S_DATA)) |=> out_valid && $stable(out_data));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);
endmodule

// File: tb/blk_wr_packetizer_tb.sv
module blk_wr_packetizer_tb;
  localparam int PERIOD = 10;
  localparam int CHUNK  = 8192;
  localparam int LEN_W  = 24;

  logic clk = 0, rst_n = 0;
  logic start = 0, crc_en = 0;
  logic [LEN_W-1:0] total_len = '0;
  logic busy, reject, done;
  logic [7:0] in_data;
  logic in_valid, in_ready;
  logic [7:0] out_data;
  logic out_valid, out_ready;

  always #(PERIOD/2) clk = ~clk;

  blk_wr_packetizer #(.CHUNK_MAX(CHUNK), .LEN_W(LEN_W), .MIN_LEN(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len), .crc_en(crc_en),
    .busy(busy), .reject(reject), .done(done),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready));

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  int cyc = 0;
  int src_idx = 0, src_len = 0;
  bit stall = 0, in_fire = 0;
  logic [7:0] q[$];
  int done_cnt = 0, done_at = 0, done_busy = 0, rej_cnt = 0, gap_cnt = 0, rdy_cnt = 0;
  int seed = 0;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 13) + (i >> 8) + seed);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // source / sink driven just after the edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (in_fire) src_idx++;
    in_valid = (src_idx < src_len) && !(stall && (cyc % 5 == 3));
    in_data  = pat(src_idx);
    out_ready = !(stall && ((cyc % 7 == 2) || (cyc % 7 == 4)));
  end

  // monitor between edges
  always @(negedge clk) begin
    in_fire = in_valid && in_ready;
    if (out_valid && out_ready) q.push_back(out_data);
    if (busy && !(out_valid && out_ready)) gap_cnt++;
    if (in_ready) rdy_cnt++;
    if (reject) rej_cnt++;
    if (done) begin
      done_cnt++;
      done_at = q.size();
      done_busy = busy;
    end
  end

  task automatic kick(int len, bit crc);
    q.delete();
    done_cnt = 0; rej_cnt = 0; gap_cnt = 0; rdy_cnt = 0;
    src_idx = 0; src_len = len;
    @(posedge clk); #2;
    start = 1; total_len = LEN_W'(len); crc_en = crc;
    @(posedge clk); #2;
    start = 0; crc_en = 0;
  endtask

  task automatic run_xfer(int len, bit crc, bit stl, string name);
    int nch, exp_len, pos, rem, bad_mark, bad_data, bad_tail, di;
    bit first;
    stall = stl;
    seed = len & 255;
    kick(len, crc);
    for (int w = 0; w < 60000 && done_cnt == 0; w++) @(negedge clk);
    @(negedge clk);
    nch = (len + CHUNK - 1) / CHUNK;
    exp_len = len + nch * (crc ? 3 : 1);
    check(q.size() == exp_len, {name, " R3 stream length"}, q.size(), exp_len);
    check(done_cnt == 1, {name, " R8 done pulses"}, done_cnt, 1);
    check(done_at == exp_len, {name, " R8 done after last byte"}, done_at, exp_len);
    check(done_busy == 0, {name, " R8 busy low at done"}, done_busy, 0);
    if (q.size() == exp_len) begin
      pos = 0; rem = len; first = 1; di = 0;
      bad_mark = 0; bad_data = 0; bad_tail = 0;
      while (rem > 0) begin
        int n, cd;
        cd = (rem <= CHUNK) ? 3 : (first ? 1 : 2);
        n  = (rem <= CHUNK) ? rem : CHUNK;
        if (q[pos] != 8'(8'hF0 | cd)) begin
          bad_mark++;
          $display("  chunk marker at %0d: got %02h want %02h", pos, q[pos], 8'hF0 | cd);
        end
        pos++;
        for (int k = 0; k < n; k++) begin
          if (q[pos] != pat(di)) bad_data++;
          pos++; di++;
        end
        if (crc) begin
          if (q[pos] != 8'h00 || q[pos+1] != 8'h00) bad_tail++;
          pos += 2;
        end
        rem -= n; first = 0;
      end
      check(bad_mark == 0, {name, (len > CHUNK) ? " R2 position codes" : " R1 position codes"}, bad_mark, 0);
      check(bad_data == 0, {name, (stl ? " R7 stalled payload" : " R3 payload")}, bad_data, 0);
      check(bad_tail == 0, {name, " R4 check bytes"}, bad_tail, 0);
    end
    if (!stl) check(gap_cnt == 0, {name, " R5 idle cycles"}, gap_cnt, 0);
    stall = 0;
  endtask

  task automatic run_refuse(int len);
    stall = 0;
    kick(len, 1'b1);
    repeat (4) @(negedge clk);
    check(rej_cnt == 1, "R6 reject pulse", rej_cnt, 1);
    check(q.size() == 0, "R6 no output bytes", q.size(), 0);
    check(rdy_cnt == 0, "R6 in_ready stays low", rdy_cnt, 0);
    check(busy == 0, "R6 busy low", busy, 0);
    check(done_cnt == 0, "R6 no done", done_cnt, 0);
  endtask

  task automatic run_reset;
    #(PERIOD*2 + 2);
    check(!busy && !done && !reject, "R9 status after reset", {busy, done, reject}, 0);
    check(!out_valid && !in_ready, "R9 handshake after reset", {out_valid, in_ready}, 0);
    rst_n = 1;
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    in_valid = 0; in_data = 0; out_ready = 1;
    run_reset();
    repeat (3) @(posedge clk);
    run_refuse(4);
    run_refuse(0);
    run_xfer(5, 1'b0, 1'b0, "len5 nocrc");
    run_xfer(5, 1'b1, 1'b0, "len5 crc");
    run_xfer(37, 1'b1, 1'b1, "len37 crc stall");
    run_xfer(CHUNK, 1'b1, 1'b0, "len=max crc");
    run_xfer(CHUNK + 1, 1'b0, 1'b0, "len=max+1 nocrc");
    run_xfer(2 * CHUNK + 10, 1'b1, 1'b1, "three chunks crc stall");
    run_xfer(2 * CHUNK + 10, 1'b0, 1'b0, "three chunks full rate");
    finish_up();
  end

  initial begin
    #(PERIOD * 190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule